// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked, single-port word memory that starts, continues or suspends a burst of four accesses at a time. Every control input except output enable is sampled on the rising clock edge. At each edge the block picks one of four actions: stay idle, start a burst at the external address, step the burst counter, or hold the current address. It then reads or writes the word at the chosen address. The word is split into independently writable byte lanes. The data bus comes out as an input, an output and a drive-enable flag, so the surrounding logic or pads can build the tri-state.

There are two ways to start a burst. A start from the processor strobe is always a read. A start from the controller strobe reads or writes according to the write controls in that same cycle. Within a burst, only the two lowest address bits move. A mode input chooses between an XOR-interleaved order and a linear order that wraps modulo four.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dq_drive` is 0 and `dq_out` is all zeros until a read cycle has taken place.
- R2: The part counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe (`pstb_n`=0 or `cstb_n`=0) while not selected makes an idle cycle: no address is used and the bus floats. Later cycles with both strobes high stay idle until a selected start.
- R3: With `ilv_mode`=1, the two low address bits of the burst are the start bits XOR a count. The count starts at 0 and rises by one for each continue cycle. The upper bits keep the start address. From start 01 the order is 01, 00, 11, 10.
- R4: With `ilv_mode`=0, the two low bits are (start + count) mod 4 and the upper bits are held. From start 10 the order is 10, 11, 00, 01.
- R5: A selected start with `pstb_n`=0 is a read, whatever the write controls show. A following cycle with both strobes high and the write asserted writes at the current burst address.
- R6: A selected start with `pstb_n`=1 and `cstb_n`=0 is a write when the effective write is asserted, and a read otherwise. Any write stores `dq_in` as sampled at that same edge.
- R7: A cycle with both strobes high and `adv_n`=1 inside a burst reuses the address of the previous cycle. With `adv_n`=0 it moves to the next burst address.
- R8: The effective write is asserted when `gwr_n`=0 (all lanes written), or when `bwr_n`=0 and at least one bit of `lane_en_n` is 0. In the second case only lanes whose bit is 0 change: bit 0 controls `dq` bits 8:0 and bit 1 controls bits 17:9. If `bwr_n`=0 and `lane_en_n`=11, the cycle is a read.
- R9: `dq_drive` is 1 only while `oe_n`=0 and the cycle at the last edge was a read, and it follows `oe_n` without waiting for a clock. While driving, `dq_out` is the word stored at that read address, including all earlier writes. Otherwise `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External word address, loaded on a burst start |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| pstb_n | input | 1 | Processor address strobe (start, read only) |
| cstb_n | input | 1 | Controller address strobe (start, read or write) |
| adv_n | input | 1 | Burst advance; low steps the counter, high suspends |
| gwr_n | input | 1 | Global write, all lanes |
| bwr_n | input | 1 | Byte-write enable |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| ilv_mode | input | 1 | 1 = interleaved burst order, 0 = linear |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driving |
| dq_drive | output | 1 | High while the block drives the data bus |

## Verification
The bench builds the block with ADDR_W = 4 and keeps the default two lanes of nine bits. At that size the reference model can write and then read back every word. A burst can also be placed where the upper address bits must stay fixed while the low two bits wrap. Keeping two lanes makes every combination of lane enables reachable, including the case with no lane enabled, which turns into a read.

// File: rtl/bsram_pkg.sv
// Shared types and the burst-order function for the burst memory.
// Assumes the burst covers exactly the two lowest address bits.
package bsram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

    // Low two address bits for a given start value and burst count.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (start ^ cnt) : 2'(start + cnt);
    endfunction

endpackage

// File: rtl/bsram_lane_gate.sv
// Turns the write strobes into one write flag per byte lane, plus the
// combined effective write. Purely combinational.
// Assumes lane_en_n bit g belongs to data lane g.
module bsram_lane_gate #(
    parameter int LANES = 2
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_en_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Global write covers every lane; byte write covers enabled lanes.
        assign lane_we[g] = !gwr_n || (!bwr_n && !lane_en_n[g]);
    end

    // The effective write is asserted as soon as any lane would be written.
    assign wr_req = |lane_we;

endmodule

// File: rtl/bsram_burst_ctrl.sv
// Decides the cycle type at each edge and keeps the burst base address
// and the 2-bit burst counter. cur_addr is the address used at this edge.
// Assumes ADDR_W >= 3, so the upper address bits are not empty.
module bsram_burst_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              wr_req,
    input  logic              ilv_mode,
    output cyc_kind_t         kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              active
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;
    logic              active_q, active_d;

    // Next-state decode: deselect, start, continue or suspend.
    always_comb begin
        base_d   = base_q;
        cnt_d    = cnt_q;
        active_d = active_q;
        kind     = CYC_IDLE;
        if (!pstb_n || !cstb_n) begin
            if (sel) begin
                base_d   = addr_i;
                cnt_d    = 2'd0;
                active_d = 1'b1;
                kind     = (!pstb_n || !wr_req) ? CYC_READ : CYC_WRITE;
            end else begin
                active_d = 1'b0;
            end
        end else if (active_q) begin
            if (!adv_n) begin
                cnt_d = cnt_q + 2'd1;
            end
            kind = wr_req ? CYC_WRITE : CYC_READ;
        end
        cur_addr = {base_d[ADDR_W-1:2], burst_lo(base_d[1:0], cnt_d, ilv_mode)};
    end

    // Burst state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            cnt_q    <= 2'd0;
            active_q <= 1'b0;
        end else begin
            base_q   <= base_d;
            cnt_q    <= cnt_d;
            active_q <= active_d;
        end
    end

    assign active = active_q;

endmodule

// File: rtl/bsram_word_store.sv
// Storage array with one write port per byte lane and one shared read
// address. Writes take effect at the clock edge; reads are combinational.
// Assumes the contents need no reset.
module bsram_word_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane write: only this lane's slice of the word is stored.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
// Top of the synchronous burst memory. Registers the read decision and
// its address at each edge, and gates the data bus with the async oe_n.
// Assumes the caller builds the tri-state from dq_out and dq_drive.
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    adv_n,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_en_n,
    input  logic                    ilv_mode,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);

    localparam int WORD_W = LANES * LANE_W;

    logic              sel;
    cyc_kind_t         kind;
    logic [ADDR_W-1:0] cur_addr;
    logic              active;
    logic [LANES-1:0]  lane_we;
    logic              wr_req;
    logic [LANES-1:0]  store_we;
    logic              rd_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [WORD_W-1:0] rdata;

    assign sel = !sel_a_n && sel_b && !sel_c_n;

    bsram_lane_gate #(.LANES(LANES)) u_gate (
        .gwr_n     (gwr_n),
        .bwr_n     (bwr_n),
        .lane_en_n (lane_en_n),
        .lane_we   (lane_we),
        .wr_req    (wr_req)
    );

    bsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .sel      (sel),
        .pstb_n   (pstb_n),
        .cstb_n   (cstb_n),
        .adv_n    (adv_n),
        .wr_req   (wr_req),
        .ilv_mode (ilv_mode),
        .kind     (kind),
        .cur_addr (cur_addr),
        .active   (active)
    );

    assign store_we = lane_we & {LANES{kind == CYC_WRITE}};

    bsram_word_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .lane_we (store_we),
        .waddr   (cur_addr),
        .wdata   (dq_in),
        .raddr   (raddr_q),
        .rdata   (rdata)
    );

    // Remember whether this edge was a read, and where it read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            raddr_q <= '0;
        end else begin
            rd_q <= (kind == CYC_READ);
            if (kind == CYC_READ) begin
                raddr_q <= cur_addr;
            end
        end
    end

    assign dq_drive = rd_q && !oe_n;
    assign dq_out   = dq_drive ? rdata : '0;

endmodule

// File: rtl/bsram_chk.sv
// Property checker for burst_sram, attached through bind below.
// Assumes it sees the top's ports and its decode signals.
module bsram_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pstb_n,
    input logic              cstb_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic              sel,
    input logic              wr_req,
    input logic              active,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              dq_drive
);

    // R2
    deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!pstb_n || !cstb_n) && !sel) |=> !dq_drive);

    // R5
    pstart_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && sel) |=> (oe_n || dq_drive));

    // R6
    cwrite_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && !cstb_n && sel && wr_req) |=> !dq_drive);

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && cstb_n && adv_n && active) |-> (cur_addr == $past(cur_addr)));

    // R9
    drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !oe_n);

endmodule

bind burst_sram bsram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pstb_n   (pstb_n),
    .cstb_n   (cstb_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .sel      (sel),
    .wr_req   (wr_req),
    .active   (active),
    .cur_addr (cur_addr),
    .dq_drive (dq_drive)
);

// File: tb/tb_burst_sram.sv
// Bench for burst_sram: a behavioural model updated at each rising edge
// and compared against the outputs at every falling edge.
module tb_burst_sram;

    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [AW-1:0] addr_i;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        pstb_n, cstb_n, adv_n, gwr_n, bwr_n;
    logic [1:0]  lane_en_n;
    logic        ilv_mode, oe_n;
    logic [17:0] dq_in;
    logic [17:0] dq_out;
    logic        dq_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req = "R1";

    logic [17:0] mmem [NW];
    bit  m_active = 0;
    int  m_base = 0;
    int  m_cnt = 0;
    bit  exp_rd = 0;
    int  exp_addr = 0;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_en_n(lane_en_n),
        .ilv_mode(ilv_mode), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic check(input logic [17:0] act_d, input logic act_v,
                         input logic [17:0] exp_d, input logic exp_v);
        checks++;
        if (act_v !== exp_v || act_d !== exp_d) begin
            errors++;
            $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h",
                     req, act_v, act_d, exp_v, exp_d);
        end
    endtask

    // One clock: update the model at the rising edge, compare at the falling one.
    task automatic tick();
        bit sel, ew;
        logic [17:0] mask;
        int kind, a;
        @(posedge clk);
        sel  = !sel_a_n && sel_b && !sel_c_n;
        ew   = !gwr_n || (!bwr_n && lane_en_n != 2'b11);
        mask = !gwr_n ? 18'h3FFFF :
               (!bwr_n ? ((lane_en_n[0] ? 18'h0 : 18'h001FF) |
                          (lane_en_n[1] ? 18'h0 : 18'h3FE00)) : 18'h0);
        kind = 0;
        if (!rst_n) begin
            m_active = 0;
        end else if (!pstb_n || !cstb_n) begin
            if (sel) begin
                m_active = 1; m_base = int'(addr_i); m_cnt = 0;
                kind = !pstb_n ? 1 : (ew ? 2 : 1);
            end else begin
                m_active = 0;
            end
        end else if (m_active) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            kind = ew ? 2 : 1;
        end
        a = (m_base & ~3) | (ilv_mode ? ((m_base & 3) ^ m_cnt)
                                      : (((m_base & 3) + m_cnt) % 4));
        if (kind == 2) mmem[a] = (mmem[a] & ~mask) | (dq_in & mask);
        exp_rd   = (kind == 1);
        exp_addr = a;
        @(negedge clk);
        if (exp_rd && !oe_n) check(dq_out, dq_drive, mmem[exp_addr], 1'b1);
        else                 check(dq_out, dq_drive, 18'h0, 1'b0);
    endtask

    task automatic quiet();
        pstb_n = 1; cstb_n = 1; adv_n = 1; gwr_n = 1; bwr_n = 1; lane_en_n = 2'b11;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    task automatic cwrite(input int a, input logic [17:0] d);
        quiet(); cstb_n = 0; gwr_n = 0; addr_i = AW'(a); dq_in = d; tick();
    endtask

    task automatic pread(input int a);
        quiet(); pstb_n = 0; addr_i = AW'(a); tick();
    endtask

    task automatic step(input bit adv, input bit wr, input logic [17:0] d);
        quiet(); adv_n = !adv; gwr_n = !wr; dq_in = d; tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; quiet(); addr_i = '0; ilv_mode = 1; oe_n = 0; dq_in = '0;
        // R1: reset state, bus floats
        req = "R1";
        tick(); tick();
        rst_n = 1;
        tick();

        // R6: controller-strobe writes fill every word
        req = "R6";
        for (int i = 0; i < NW; i++) cwrite(i, 18'((i * 18'h1357) ^ 18'h2A5A5));

        // R5: processor start reads even with global write low
        req = "R5";
        quiet(); pstb_n = 0; gwr_n = 0; addr_i = 4'd5; tick();
        // R3: interleaved continue from 5: 5,4,7,6
        req = "R3";
        step(1, 0, '0); step(1, 0, '0); step(1, 0, '0);

        // R4: linear burst from 6: 6,7,4,5
        req = "R4";
        ilv_mode = 0;
        pread(6); step(1, 0, '0); step(1, 0, '0); step(1, 0, '0);

        // R7: suspend holds the address, then advance moves on
        req = "R7";
        pread(13); step(0, 0, '0); step(0, 0, '0); step(1, 0, '0); step(0, 0, '0);
        ilv_mode = 1;

        // R8: byte write to lane 0 only at word 3, then read back
        req = "R8";
        quiet(); cstb_n = 0; bwr_n = 0; lane_en_n = 2'b10; addr_i = 4'd3; dq_in = 18'h3FFFF; tick();
        pread(3);
        quiet(); cstb_n = 0; bwr_n = 0; lane_en_n = 2'b01; addr_i = 4'd3; dq_in = 18'h00000; tick();
        pread(3);
        // R8: byte write with no lane enabled is a read, word unchanged
        quiet(); cstb_n = 0; bwr_n = 0; lane_en_n = 2'b11; addr_i = 4'd3; dq_in = 18'h12345; tick();

        // R5: read start then write on the wait cycle, then read back
        req = "R5";
        pread(9); step(0, 1, 18'h0BEEF); pread(9);

        // R6: burst write from 12 with continues, then read back in order
        req = "R6";
        cwrite(12, 18'h11111); step(1, 1, 18'h22222); step(1, 1, 18'h33333); step(1, 1, 18'h04444);
        pread(12); step(1, 0, '0); step(1, 0, '0); step(1, 0, '0);

        // R2: strobes while deselected leave the bus floating, even on continues
        req = "R2";
        pread(1);
        quiet(); sel_b = 0; cstb_n = 0; gwr_n = 0; addr_i = 4'd1; dq_in = 18'h3AAAA; tick();
        step(1, 0, '0); step(1, 1, 18'h15555);
        quiet(); sel_a_n = 1; pstb_n = 0; addr_i = 4'd2; tick();
        quiet(); sel_c_n = 1; pstb_n = 0; addr_i = 4'd2; tick();
        pread(1); pread(2);

        // R9: output enable acts without a clock; writes never drive
        req = "R9";
        pread(7);
        oe_n = 1; #1 check(dq_out, dq_drive, 18'h0, 1'b0);
        oe_n = 0; #1 check(dq_out, dq_drive, mmem[7], 1'b1);
        oe_n = 1; step(0, 0, '0);
        oe_n = 0; cwrite(7, 18'h2F0F0);
        pread(7);
        quiet(); tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule